// File: doc/BRIEF.md
# Flash Write-Command Sequence Decoder

This block sits behind the asynchronous bus of a word-wide flash memory and turns multi-write command sequences into one-cycle operation requests. Every write is qualified by chip enable, write enable and output enable, all sampled on the core clock. The target address is captured when write enable falls, and the data when write enable rises. The decoder tracks the two-write unlock prefix and any setup writes. When a sequence completes, it raises exactly one pulse: a word program with its latched address and data, a chip erase, a sector erase, a boot-lock set, an identification-mode entry or an identification-mode exit.

Erase requests carry a four-bit block mask. Bit 0 is the boot block, bit 1 is parameter block 1, bit 2 is parameter block 2 and bit 3 is the main block. A sticky lock bit protects the boot block. Only the lock command sets it, the sequence reset leaves it alone, and the power-on reset clears it. A high-voltage override input suspends the lock for as long as it is asserted.

While identification mode is active, reads return the maker code, a device code or the lock state instead of array data. The array, the program and erase timers and the output drivers are outside this block. The core-side pins are single-cycle pulses and levels with no handshake, because the array engine accepts one command at a time. The bus side follows the memory's own strobes, not valid/ready.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write counts only when ce_n and we_n are low and oe_n is high. The address is taken in the cycle where we_n falls, and the data in the cycle where we_n rises. A write made with oe_n low changes no state.
- R2: Every command starts with low byte AA written to command address 5555, then low byte 55 written to 2AAA. Command addresses compare bits 14:0 only, and command data compares bits 7:0 only. A write that does not match the expected step returns the decoder to idle and has no other effect.
- R3: The sequence AA, 55, A0 at 5555, then one write to any address, raises prog_start_o for exactly one cycle. The pulse appears in the clock cycle after the data-rising edge. prog_addr_o and prog_data_o hold that write's full address and full data word.
- R4: The sequence AA, 55, 80, AA, 55, 10 (the last at 5555) raises erase_start_o with mask 1111 when unlocked.
- R5: The same five setup writes, followed by 30 at a sector address, raise erase_start_o. Address bits 16:12 decide the mask: 03 gives 0010, 05 gives 0100, and 1F gives 1001 when unlocked. Any other value raises no pulse.
- R6: The same five setup writes, followed by 40 at 5555, pulse lock_set_o and set lock_o. lock_o then stays set through rst_n and is cleared only by por_n.
- R7: While lock_o is set and the override is low, a word program whose address lies in 00000–01FFF raises no pulse. Chip erase uses mask 1110, and sector erase at 1Fxxx uses mask 1000.
- R8: While hv_unlock_i is high, the lock is suspended: the R4 and R5 masks and R3 programs into the boot block apply again.
- R9: AA, 55, 90 at 5555 pulses id_enter_o and sets id_mode_o. Any write with low byte F0, outside the program data write, pulses id_exit_o, clears id_mode_o and returns the decoder to idle.
- R10: In identification mode, id_data_o follows the read address. Address 0 gives 00DA. Address 1 gives 0FAE when async_sel_i is low and 00AE when it is high. Address 2 gives the lock bit in bit 0. Outside identification mode, id_data_o is 0000.
- R11: After reset all pulses, id_mode_o and id_data_o are low, and at most one operation pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Sequence reset, active low (lock kept) |
| por_n | input | 1 | Power-on reset, active low (clears lock) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | 17 | Word address |
| data_i | input | 16 | Write data |
| async_sel_i | input | 1 | Read mode select, high for asynchronous reads |
| hv_unlock_i | input | 1 | High-voltage lock override |
| prog_start_o | output | 1 | Word program request pulse |
| prog_addr_o | output | 17 | Program address |
| prog_data_o | output | 16 | Program data |
| erase_start_o | output | 1 | Erase request pulse |
| erase_mask_o | output | 4 | Blocks to erase with the pulse |
| lock_set_o | output | 1 | Boot-lock set pulse |
| id_enter_o | output | 1 | Identification entry pulse |
| id_exit_o | output | 1 | Identification exit pulse |
| id_mode_o | output | 1 | Identification mode active |
| lock_o | output | 1 | Boot lock state |
| id_data_o | output | 16 | Identification read data |

## Verification
The decoder is driven with every complete command, and with each one again after a broken prefix, so that a correct sequence can be told apart from one that is only partly matched. Writes with stray upper address bits and a stray upper data byte show that only the command fields are compared. Sector addresses inside and outside the three valid codes separate the decode from a plain data match. Each lock-sensitive command is repeated unlocked, locked, and locked with the override, which shows that the lock changes the mask or blocks the pulse and that the override restores the unlocked result.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW  = 15;
  localparam int CMD_DW  = 8;
  localparam int NBLK    = 4;

  localparam logic [CMD_AW-1:0] A_FIRST  = 15'h5555;
  localparam logic [CMD_AW-1:0] A_SECOND = 15'h2AAA;

  localparam logic [CMD_DW-1:0] D_KEY1  = 8'hAA;
  localparam logic [CMD_DW-1:0] D_KEY2  = 8'h55;
  localparam logic [CMD_DW-1:0] D_PROG  = 8'hA0;
  localparam logic [CMD_DW-1:0] D_SETUP = 8'h80;
  localparam logic [CMD_DW-1:0] D_IDIN  = 8'h90;
  localparam logic [CMD_DW-1:0] D_IDOUT = 8'hF0;
  localparam logic [CMD_DW-1:0] D_CHIP  = 8'h10;
  localparam logic [CMD_DW-1:0] D_SECT  = 8'h30;
  localparam logic [CMD_DW-1:0] D_LOCK  = 8'h40;

  // erase mask bit positions
  localparam int B_BOOT = 0;
  localparam int B_PAR1 = 1;
  localparam int B_PAR2 = 2;
  localparam int B_MAIN = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_KEY2, S_PROGW, S_SET, S_SETK1, S_SETK2
  } seq_state_t;
endpackage

// File: rtl/flash_cmd_wcap.sv
module flash_cmd_wcap #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic we_q, armed_q;
  logic sel, fall, rise;

  assign sel  = ~ce_n & oe_n;
  assign fall = we_q & ~we_n;
  assign rise = ~we_q & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      armed_q <= 1'b0;
      addr_o  <= '0;
    end else begin
      we_q <= we_n;
      if (fall && sel) begin
        armed_q <= 1'b1;
        addr_o  <= addr_i;
      end else if (rise) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign commit_o = rise & armed_q & sel;
  assign data_o   = data_i;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int BOOT_AW = 13,
  parameter int SECT_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_eff_i,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              erase_start_o,
  output logic [NBLK-1:0]   erase_mask_o,
  output logic              lock_set_o,
  output logic              id_enter_o,
  output logic              id_exit_o,
  output logic              id_mode_o
);
  localparam int SEL_W = ADDR_W - SECT_AW;
  localparam logic [SEL_W-1:0] SEL_PAR1 = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_PAR2 = SEL_W'(5);
  localparam logic [SEL_W-1:0] SEL_MAIN = '1;

  seq_state_t st_q, st_n;
  logic prog_n, erase_n, lock_n, enter_n, exit_n, idm_n;
  logic [NBLK-1:0] mask_n, sect_mask;
  logic [CMD_AW-1:0] ca;
  logic [CMD_DW-1:0] cd;
  logic boot_hit, at_first, at_second;

  assign ca        = waddr_i[CMD_AW-1:0];
  assign cd        = wdata_i[CMD_DW-1:0];
  assign at_first  = (ca == A_FIRST);
  assign at_second = (ca == A_SECOND);
  assign boot_hit  = (waddr_i[ADDR_W-1:BOOT_AW] == '0);

  always_comb begin
    sect_mask = '0;
    case (waddr_i[ADDR_W-1:SECT_AW])
      SEL_PAR1: sect_mask[B_PAR1] = 1'b1;
      SEL_PAR2: sect_mask[B_PAR2] = 1'b1;
      SEL_MAIN: begin
        sect_mask[B_MAIN] = 1'b1;
        sect_mask[B_BOOT] = ~lock_eff_i;
      end
      default: sect_mask = '0;
    endcase
  end

  always_comb begin
    st_n    = st_q;
    prog_n  = 1'b0;
    erase_n = 1'b0;
    mask_n  = '0;
    lock_n  = 1'b0;
    enter_n = 1'b0;
    exit_n  = 1'b0;
    idm_n   = id_mode_o;
    if (commit_i) begin
      st_n = S_IDLE;
      if (st_q != S_PROGW && cd == D_IDOUT) begin
        exit_n = 1'b1;
        idm_n  = 1'b0;
      end else begin
        case (st_q)
          S_IDLE:  if (at_first && cd == D_KEY1) st_n = S_KEY1;
          S_KEY1:  if (at_second && cd == D_KEY2) st_n = S_KEY2;
          S_KEY2: if (at_first) begin
            if (cd == D_PROG) st_n = S_PROGW;
            else if (cd == D_SETUP) st_n = S_SET;
            else if (cd == D_IDIN) begin
              enter_n = 1'b1;
              idm_n   = 1'b1;
            end
          end
          S_PROGW: prog_n = ~(lock_eff_i & boot_hit);
          S_SET:   if (at_first && cd == D_KEY1) st_n = S_SETK1;
          S_SETK1: if (at_second && cd == D_KEY2) st_n = S_SETK2;
          S_SETK2: begin
            if (at_first && cd == D_CHIP) begin
              erase_n = 1'b1;
              mask_n  = '1;
              mask_n[B_BOOT] = ~lock_eff_i;
            end else if (at_first && cd == D_LOCK) begin
              lock_n = 1'b1;
            end else if (cd == D_SECT && sect_mask != '0) begin
              erase_n = 1'b1;
              mask_n  = sect_mask;
            end
          end
          default: st_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      erase_mask_o  <= '0;
      lock_set_o    <= 1'b0;
      id_enter_o    <= 1'b0;
      id_exit_o     <= 1'b0;
      id_mode_o     <= 1'b0;
      prog_addr_o   <= '0;
      prog_data_o   <= '0;
    end else begin
      st_q          <= st_n;
      prog_start_o  <= prog_n;
      erase_start_o <= erase_n;
      erase_mask_o  <= mask_n;
      lock_set_o    <= lock_n;
      id_enter_o    <= enter_n;
      id_exit_o     <= exit_n;
      id_mode_o     <= idm_n;
      if (prog_n) begin
        prog_addr_o <= waddr_i;
        prog_data_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_idrd.sv
module flash_cmd_idrd #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MAKER_CODE = 16'h00DA,
  parameter logic [DATA_W-1:0] DEV_SYNC   = 16'h0FAE,
  parameter logic [DATA_W-1:0] DEV_ASYNC  = 16'h00AE
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              async_sel_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (id_mode_i && addr_i[ADDR_W-1:2] == '0) begin
      case (addr_i[1:0])
        2'd0: data_o = MAKER_CODE;
        2'd1: data_o = async_sel_i ? DEV_ASYNC : DEV_SYNC;
        2'd2: data_o = {{(DATA_W-1){1'b0}}, lock_i};
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  parameter int BOOT_AW = 13,
  parameter int SECT_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              async_sel_i,
  input  logic              hv_unlock_i,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              erase_start_o,
  output logic [NBLK-1:0]   erase_mask_o,
  output logic              lock_set_o,
  output logic              id_enter_o,
  output logic              id_exit_o,
  output logic              id_mode_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic              seq_rst_n;
  logic              commit;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic              lock_q;

  assign seq_rst_n = rst_n & por_n;

  flash_cmd_wcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wcap_i (
    .clk(clk), .rst_n(seq_rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_i(addr_i), .data_i(data_i),
    .commit_o(commit), .addr_o(waddr), .data_o(wdata)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_AW(BOOT_AW),
                  .SECT_AW(SECT_AW)) fsm_i (
    .clk(clk), .rst_n(seq_rst_n), .commit_i(commit), .waddr_i(waddr),
    .wdata_i(wdata), .lock_eff_i(lock_q & ~hv_unlock_i),
    .prog_start_o(prog_start_o), .prog_addr_o(prog_addr_o),
    .prog_data_o(prog_data_o), .erase_start_o(erase_start_o),
    .erase_mask_o(erase_mask_o), .lock_set_o(lock_set_o),
    .id_enter_o(id_enter_o), .id_exit_o(id_exit_o), .id_mode_o(id_mode_o)
  );

  // sticky boot lock: only the power-on reset clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          lock_q <= 1'b0;
    else if (lock_set_o) lock_q <= 1'b1;
  end
  assign lock_o = lock_q;

  flash_cmd_idrd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) idrd_i (
    .id_mode_i(id_mode_o), .addr_i(addr_i), .async_sel_i(async_sel_i),
    .lock_i(lock_q), .data_o(id_data_o)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  parameter int BOOT_AW = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              hv_unlock_i,
  input logic              prog_start_o,
  input logic [ADDR_W-1:0] prog_addr_o,
  input logic              erase_start_o,
  input logic [3:0]        erase_mask_o,
  input logic              lock_set_o,
  input logic              id_enter_o,
  input logic              id_exit_o,
  input logic              id_mode_o,
  input logic              lock_o
);
  p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $onehot0({prog_start_o, erase_start_o, lock_set_o, id_enter_o, id_exit_o}));

  p_prog_single_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_start_o |=> !prog_start_o);

  p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    erase_start_o |-> erase_mask_o != 4'b0000);

  p_locked_prog_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_start_o |-> !($past(lock_o && !hv_unlock_i) &&
                       prog_addr_o[ADDR_W-1:BOOT_AW] == '0));

  p_locked_erase_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (erase_start_o && $past(lock_o && !hv_unlock_i)) |-> !erase_mask_o[0]);

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    lock_o |=> lock_o);

  p_id_enter_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(id_mode_o) |-> id_enter_o);

  p_id_exit_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    id_exit_o |-> !id_mode_o);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                                               .BOOT_AW(BOOT_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .hv_unlock_i(hv_unlock_i),
  .prog_start_o(prog_start_o), .prog_addr_o(prog_addr_o),
  .erase_start_o(erase_start_o), .erase_mask_o(erase_mask_o),
  .lock_set_o(lock_set_o), .id_enter_o(id_enter_o), .id_exit_o(id_exit_o),
  .id_mode_o(id_mode_o), .lock_o(lock_o)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [15:0] data = '0;
  logic async_sel = 1'b0, hv = 1'b0;
  logic prog_start, erase_start, lock_set, id_enter, id_exit, id_mode, lock;
  logic [16:0] prog_addr;
  logic [15:0] prog_data, id_data;
  logic [3:0] erase_mask;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr_i(addr), .data_i(data), .async_sel_i(async_sel),
    .hv_unlock_i(hv), .prog_start_o(prog_start), .prog_addr_o(prog_addr),
    .prog_data_o(prog_data), .erase_start_o(erase_start),
    .erase_mask_o(erase_mask), .lock_set_o(lock_set), .id_enter_o(id_enter),
    .id_exit_o(id_exit), .id_mode_o(id_mode), .lock_o(lock), .id_data_o(id_data)
  );

  // observed: {prog, erase, mask[3:0], lock_set, id_enter, id_exit, id_mode}
  function automatic logic [9:0] obs();
    return {prog_start, erase_start, erase_mask, lock_set, id_enter, id_exit, id_mode};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d, input logic oe_lvl);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = oe_lvl; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; data = d;
    @(negedge clk); oe_n = 1'b1;
  endtask

  task automatic setup5();
    wr(17'h05555, 16'h00AA, 1'b1); wr(17'h02AAA, 16'h0055, 1'b1);
    wr(17'h05555, 16'h0080, 1'b1); wr(17'h05555, 16'h00AA, 1'b1);
    wr(17'h02AAA, 16'h0055, 1'b1);
  endtask

  task automatic unlock3(input logic [7:0] c);
    wr(17'h05555, 16'h00AA, 1'b1); wr(17'h02AAA, 16'h0055, 1'b1);
    wr(17'h05555, {8'h00, c}, 1'b1);
  endtask

  task automatic rd(input logic [16:0] a);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; #1;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // {addr[16:0], data[15:0], expected obs[9:0], requirement number[3:0]}
  localparam int NV = 48;
  localparam logic [46:0] VEC [NV] = '{
    {17'h05555, 16'h00AA, 10'h000, 4'd2}, {17'h02AAA, 16'h0055, 10'h000, 4'd2},
    {17'h05555, 16'h00A0, 10'h000, 4'd3}, {17'h00123, 16'h1234, 10'h200, 4'd3}, // R3
    {17'h05555, 16'h00AA, 10'h000, 4'd4}, {17'h02AAA, 16'h0055, 10'h000, 4'd4},
    {17'h05555, 16'h0080, 10'h000, 4'd4}, {17'h05555, 16'h00AA, 10'h000, 4'd4},
    {17'h02AAA, 16'h0055, 10'h000, 4'd4}, {17'h05555, 16'h0010, 10'h1F0, 4'd4}, // R4
    {17'h05555, 16'h00AA, 10'h000, 4'd9}, {17'h02AAA, 16'h0055, 10'h000, 4'd9},
    {17'h05555, 16'h0090, 10'h005, 4'd9}, {17'h00000, 16'h00F0, 10'h002, 4'd9}, // R9
    {17'h05555, 16'h00AA, 10'h000, 4'd5}, {17'h02AAA, 16'h0055, 10'h000, 4'd5},
    {17'h05555, 16'h0080, 10'h000, 4'd5}, {17'h05555, 16'h00AA, 10'h000, 4'd5},
    {17'h02AAA, 16'h0055, 10'h000, 4'd5}, {17'h05ABC, 16'h0030, 10'h140, 4'd5}, // R5
    {17'h05555, 16'h00AA, 10'h000, 4'd5}, {17'h02AAA, 16'h0055, 10'h000, 4'd5},
    {17'h05555, 16'h0080, 10'h000, 4'd5}, {17'h05555, 16'h00AA, 10'h000, 4'd5},
    {17'h02AAA, 16'h0055, 10'h000, 4'd5}, {17'h03000, 16'h0030, 10'h120, 4'd5},
    {17'h05555, 16'h00AA, 10'h000, 4'd5}, {17'h02AAA, 16'h0055, 10'h000, 4'd5},
    {17'h05555, 16'h0080, 10'h000, 4'd5}, {17'h05555, 16'h00AA, 10'h000, 4'd5},
    {17'h02AAA, 16'h0055, 10'h000, 4'd5}, {17'h1F000, 16'h0030, 10'h190, 4'd5},
    {17'h05555, 16'h00AA, 10'h000, 4'd2}, {17'h02AAA, 16'h0056, 10'h000, 4'd2}, // R2 broken
    {17'h05555, 16'h00A0, 10'h000, 4'd2}, {17'h00100, 16'h1234, 10'h000, 4'd2},
    {17'h1D555, 16'hFFAA, 10'h000, 4'd2}, {17'h02AAA, 16'h3355, 10'h000, 4'd2}, // R2 masking
    {17'h05555, 16'h0090, 10'h005, 4'd2}, {17'h05555, 16'h00AA, 10'h001, 4'd9},
    {17'h02AAA, 16'h0055, 10'h001, 4'd9}, {17'h05555, 16'h00F0, 10'h002, 4'd9},
    {17'h05555, 16'h00AA, 10'h000, 4'd5}, {17'h02AAA, 16'h0055, 10'h000, 4'd5},
    {17'h05555, 16'h0080, 10'h000, 4'd5}, {17'h05555, 16'h00AA, 10'h000, 4'd5},
    {17'h02AAA, 16'h0055, 10'h000, 4'd5}, {17'h07000, 16'h0030, 10'h000, 4'd5}  // R5 bad sector
  };

  initial begin
    #1_600_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset pulses", {22'd0, obs()}, 32'd0);
    chk("R11 reset lock", {31'd0, lock}, 32'd0);
    chk("R11 reset id_data", {16'd0, id_data}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][46:30], VEC[i][29:14], 1'b1);
      chk($sformatf("R%0d table row %0d", VEC[i][3:0], i),
          {22'd0, obs()}, {22'd0, VEC[i][13:4]});
    end

    // R3 latched address and data, single-cycle pulse
    unlock3(8'hA0); wr(17'h1ABCD, 16'hBEEF, 1'b1);
    chk("R3 prog pulse", {31'd0, prog_start}, 32'd1);
    chk("R3 prog addr", {15'd0, prog_addr}, 32'h1ABCD);
    chk("R3 prog data", {16'd0, prog_data}, 32'hBEEF);
    @(negedge clk);
    chk("R3 pulse one cycle", {31'd0, prog_start}, 32'd0);

    // R10 identification reads
    unlock3(8'h90);
    async_sel = 1'b0; rd(17'h00000);
    chk("R10 maker code", {16'd0, id_data}, 32'h00DA);
    rd(17'h00001);
    chk("R10 device sync", {16'd0, id_data}, 32'h0FAE);
    async_sel = 1'b1; #1;
    chk("R10 device async", {16'd0, id_data}, 32'h00AE);
    rd(17'h00002);
    chk("R10 lock read unlocked", {16'd0, id_data}, 32'h0000);

    // R1 write with oe_n low is ignored
    wr(17'h00000, 16'h00F0, 1'b0);
    chk("R1 oe-low write ignored", {31'd0, id_mode}, 32'd1);
    wr(17'h00000, 16'h00F0, 1'b1);
    chk("R9 single F0 exit", {31'd0, id_mode}, 32'd0);
    rd(17'h00000);
    chk("R10 id_data outside id mode", {16'd0, id_data}, 32'h0000);

    // R6 lock set
    setup5(); wr(17'h05555, 16'h0040, 1'b1);
    chk("R6 lock pulse", {31'd0, lock_set}, 32'd1);
    @(negedge clk);
    chk("R6 lock set", {31'd0, lock}, 32'd1);

    // R7 locked behaviour
    setup5(); wr(17'h05555, 16'h0010, 1'b1);
    chk("R7 chip erase locked", {27'd0, erase_start, erase_mask}, 32'h1E);
    setup5(); wr(17'h1F123, 16'h0030, 1'b1);
    chk("R7 sector main locked", {27'd0, erase_start, erase_mask}, 32'h18);
    unlock3(8'hA0); wr(17'h01000, 16'h5A5A, 1'b1);
    chk("R7 boot program blocked", {31'd0, prog_start}, 32'd0);
    unlock3(8'hA0); wr(17'h02000, 16'h5A5A, 1'b1);
    chk("R7 non-boot program", {31'd0, prog_start}, 32'd1);
    unlock3(8'h90); rd(17'h00002);
    chk("R10 lock read locked", {16'd0, id_data}, 32'h0001);
    wr(17'h00000, 16'h00F0, 1'b1);

    // R8 override
    hv = 1'b1;
    setup5(); wr(17'h05555, 16'h0010, 1'b1);
    chk("R8 chip erase override", {27'd0, erase_start, erase_mask}, 32'h1F);
    unlock3(8'hA0); wr(17'h00010, 16'h1111, 1'b1);
    chk("R8 boot program override", {31'd0, prog_start}, 32'd1);
    hv = 1'b0;

    // R6 lock survives rst_n, cleared by por_n
    unlock3(8'h90);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R11 rst clears id mode", {31'd0, id_mode}, 32'd0);
    chk("R6 lock kept over rst", {31'd0, lock}, 32'd1);
    por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    chk("R6 por clears lock", {31'd0, lock}, 32'd0);

    finish_run();
  end
endmodule